// File: doc/BRIEF.md
# Modular Fibonacci Checksum Descrambler

This block undoes a modular Fibonacci scrambler. The scrambler folds each 18-bit message word into a pair of running sums. The sums are kept modulo 258114, and the carry out of each reduction is fed back into the next step. The descrambler accepts one scrambled word per step and returns the message word that produced it. It does this with a local copy of the scrambler's second running sum, built from the previous scrambled word, and with a borrow bit that is carried from one step to the next.

Each step takes two clock cycles, run by a two-state controller:

- `PH_ACCEPT` is the decumulation phase. In it the block waits for `in_valid`.
- `PH_REDUCE` is the modulo-fix phase.

The controller has three transitions:

- **accept**: `PH_ACCEPT` to `PH_REDUCE`, taken on a valid word below the modulus.
- **reject**: `PH_ACCEPT` to `PH_ACCEPT`, taken on a valid word at or above the modulus. The reject sets the sticky error flag.
- **finish**: `PH_REDUCE` to `PH_ACCEPT`, taken unconditionally. It publishes the recovered word.

The subtraction in the decumulation phase is written as the scrambled word plus the complemented tracker plus the inverted borrow. Because of this, each of the two lanes needs only one adder, and that adder has a single carry input. Both adders are reused by the fix phase.

Top module: `mfd_descrambler`

## Requirements
- R1: After a synchronous reset:
  - the tracker holds 111981 and the previous-word register holds 56247;
  - the borrow and tracker-carry bits are 0;
  - `msg_valid` and `err` are 0, and `msg_word` is 0.
- R2: A word accepted at a rising edge produces `msg_valid` high after the second following rising edge. `msg_valid` is high for exactly one cycle per accepted word.
- R3: When the block is fed, from reset, the output of the matching scrambler (initial sums 56247 and 111981, modulus 258114), every `msg_word` equals the message word given to the scrambler.
- R4: The result is `in_word` − tracker − borrow. If that is negative, 258114 is added and the borrow becomes 1. A nonzero borrow takes one extra unit off the next step.
- R5: The tracker becomes the previous word + tracker + tracker carry. If the sum is 258114 or more, 258114 is removed and the tracker carry becomes 1 for the next step. Otherwise the tracker carry becomes 0.
- R6: `in_valid` and `in_word` are ignored during `PH_REDUCE`. The controller always returns to `PH_ACCEPT`.
- R7: A word of 258114 or more offered in `PH_ACCEPT` sets `err`. `err` stays set until reset. The word is discarded without changing any state and without a `msg_valid` pulse.
- R8: `msg_word` is always below 258114 when valid. It holds its value until the next `msg_valid`.
- R9: While `in_valid` is low, `msg_word` does not change and `msg_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Scrambled word present |
| in_word | input | 18 | Scrambled word |
| msg_valid | output | 1 | One-cycle strobe: recovered word ready |
| msg_word | output | 18 | Recovered message word |
| err | output | 1 | Sticky out-of-range input flag |

## Verification
A wrong tracker value or a lost tracker carry does not show on the same step. It appears one step later, as a recovered word that is off by the error, and every later word stays wrong. The chained scrambler-descrambler runs therefore catch it within two steps.

A lost or inverted borrow shows as an off-by-one in the very next `msg_word`. A controller fault shows directly at the ports, in the timing of `msg_valid` or in a missing `err`. Directed sequences from reset force each borrow and carry combination with hand-computed results.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
    typedef enum logic [0:0] {
        PH_ACCEPT = 1'b0,
        PH_REDUCE = 1'b1
    } phase_t;
endpackage

// File: rtl/mfd_ctrl.sv
module mfd_ctrl
    import mfd_pkg::*;
#(
    parameter int unsigned WORD_W  = 18,
    parameter int unsigned MODULUS = 258114
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output phase_t            phase,
    output logic              step_go,
    output logic              fix_go,
    output logic              out_valid,
    output logic              err
);
    localparam logic [WORD_W-1:0] MOD_W = WORD_W'(MODULUS);

    phase_t state_q, state_d;
    logic   word_ok;
    logic   err_q, valid_q;

    assign word_ok = (in_word < MOD_W);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_ACCEPT: if (in_valid && word_ok) state_d = PH_REDUCE;
            PH_REDUCE: state_d = PH_ACCEPT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_ACCEPT;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (state_q == PH_REDUCE);
            if (state_q == PH_ACCEPT && in_valid && !word_ok) err_q <= 1'b1;
        end
    end

    assign phase     = state_q;
    assign step_go   = (state_q == PH_ACCEPT) && in_valid && word_ok;
    assign fix_go    = (state_q == PH_REDUCE);
    assign out_valid = valid_q;
    assign err       = err_q;

    assert_step_latency_R2: assert property (@(posedge clk) disable iff (rst)
        step_go |-> ##2 out_valid);
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    assert_reduce_returns_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_REDUCE) |=> (state_q == PH_ACCEPT));
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    assert_bad_word_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_ACCEPT && in_valid && in_word >= MOD_W) |=> (state_q == PH_ACCEPT && err));
endmodule

// File: rtl/mfd_msg_lane.sv
module mfd_msg_lane #(
    parameter int unsigned WORD_W  = 18,
    parameter int unsigned MODULUS = 258114
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_go,
    input  logic              fix_go,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] trk_word,
    output logic [WORD_W-1:0] msg_word
);
    localparam int unsigned SUM_W = WORD_W + 1;

    logic [SUM_W-1:0]  acc_q;
    logic              borrow_q;
    logic [WORD_W-1:0] msg_q;
    logic [SUM_W-1:0]  op_a, op_b, sum;
    logic              cin;

    // Shared adder: decumulation = word + ~trk + !borrow; fix = acc + modulus.
    always_comb begin
        if (step_go) begin
            op_a = {1'b0, in_word};
            op_b = ~{1'b0, trk_word};
            cin  = ~borrow_q;
        end else begin
            op_a = acc_q;
            op_b = SUM_W'(MODULUS);
            cin  = 1'b0;
        end
        sum = op_a + op_b + {{(SUM_W-1){1'b0}}, cin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            borrow_q <= 1'b0;
            msg_q    <= '0;
        end else if (step_go) begin
            acc_q <= sum;
        end else if (fix_go) begin
            borrow_q <= acc_q[WORD_W];
            if (acc_q[WORD_W]) begin
                acc_q <= {1'b0, sum[WORD_W-1:0]};
                msg_q <= sum[WORD_W-1:0];
            end else begin
                msg_q <= acc_q[WORD_W-1:0];
            end
        end
    end

    assign msg_word = msg_q;

    assert_msg_range_R8: assert property (@(posedge clk) disable iff (rst)
        fix_go |=> (msg_q < WORD_W'(MODULUS)));
    assert_borrow_clean_R4: assert property (@(posedge clk) disable iff (rst)
        fix_go |=> !acc_q[WORD_W]);
    assert_msg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !fix_go |=> $stable(msg_q));
endmodule

// File: rtl/mfd_track_lane.sv
module mfd_track_lane #(
    parameter int unsigned WORD_W  = 18,
    parameter int unsigned MODULUS = 258114,
    parameter int unsigned INIT_T  = 56247,
    parameter int unsigned INIT_B  = 111981
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_go,
    input  logic              fix_go,
    input  logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] trk_word
);
    localparam int unsigned SUM_W  = WORD_W + 1;
    localparam int unsigned ADJUST = (1 << WORD_W) - MODULUS;

    logic [SUM_W-1:0]  trk_q;
    logic [WORD_W-1:0] prev_q;
    logic              carry_q;
    logic [SUM_W-1:0]  op_b, sum;
    logic              cin;

    // Shared adder: decumulation = trk + prev + carry; fix = trk + adjust.
    always_comb begin
        if (step_go) begin
            op_b = {1'b0, prev_q};
            cin  = carry_q;
        end else begin
            op_b = SUM_W'(ADJUST);
            cin  = 1'b0;
        end
        sum = trk_q + op_b + {{(SUM_W-1){1'b0}}, cin};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q   <= SUM_W'(INIT_B);
            prev_q  <= WORD_W'(INIT_T);
            carry_q <= 1'b0;
        end else if (step_go) begin
            trk_q  <= sum;
            prev_q <= in_word;
        end else if (fix_go) begin
            carry_q <= sum[WORD_W];
            if (sum[WORD_W]) trk_q <= {1'b0, sum[WORD_W-1:0]};
        end
    end

    assign trk_word = trk_q[WORD_W-1:0];

    assert_tracker_range_R5: assert property (@(posedge clk) disable iff (rst)
        fix_go |=> (trk_q < SUM_W'(MODULUS)));
    assert_prev_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !step_go |=> $stable(prev_q));
endmodule

// File: rtl/mfd_descrambler.sv
module mfd_descrambler
    import mfd_pkg::*;
#(
    parameter int unsigned WORD_W  = 18,
    parameter int unsigned MODULUS = 258114,
    parameter int unsigned INIT_T  = 56247,
    parameter int unsigned INIT_B  = 111981
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              msg_valid,
    output logic [WORD_W-1:0] msg_word,
    output logic              err
);
    phase_t            phase;
    logic              step_go, fix_go;
    logic [WORD_W-1:0] trk_word;

    mfd_ctrl #(.WORD_W(WORD_W), .MODULUS(MODULUS)) u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .phase(phase), .step_go(step_go), .fix_go(fix_go),
        .out_valid(msg_valid), .err(err)
    );

    mfd_msg_lane #(.WORD_W(WORD_W), .MODULUS(MODULUS)) u_msg (
        .clk(clk), .rst(rst), .step_go(step_go), .fix_go(fix_go),
        .in_word(in_word), .trk_word(trk_word), .msg_word(msg_word)
    );

    mfd_track_lane #(.WORD_W(WORD_W), .MODULUS(MODULUS),
                     .INIT_T(INIT_T), .INIT_B(INIT_B)) u_trk (
        .clk(clk), .rst(rst), .step_go(step_go), .fix_go(fix_go),
        .in_word(in_word), .trk_word(trk_word)
    );

    assert_valid_after_reduce_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REDUCE) |=> msg_valid);
endmodule

// File: tb/test_mfd_descrambler.sv
module test_mfd_descrambler;
    localparam int CLK_PERIOD = 10;
    localparam int MODV       = 258114;
    localparam int ADJV       = 262144 - MODV;
    localparam int SX0        = 56247;
    localparam int SY0        = 111981;
    localparam int N_VEC      = 12;
    localparam int WATCHDOG   = 150000;

    // {message, idle cycles after the step}
    localparam int VEC [N_VEC][2] = '{
        '{0, 0}, '{1, 1}, '{258113, 0}, '{258112, 2}, '{12345, 0},
        '{131072, 3}, '{262143 - 4030, 0}, '{77777, 1}, '{2, 0},
        '{200000, 0}, '{65535, 2}, '{146133, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [17:0] in_word = '0;
    logic        msg_valid;
    logic [17:0] msg_word;
    logic        err;

    int checks = 0;
    int errors = 0;
    int sx, sy, sv, sw;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfd_descrambler i_mfd_descrambler (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .msg_valid(msg_valid), .msg_word(msg_word), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic scr_reset();
        sx = SX0; sy = SY0; sv = 0; sw = 0;
    endtask

    function automatic int scr_step(input int m);
        int nx, ny;
        nx = m + sy + sv;
        ny = sx + sy + sw;
        sx = nx; sy = ny;
        sv = ((sx + ADJV) >> 18) & 1;
        if (sv != 0) sx = (sx + ADJV) & 262143;
        sw = ((sy + ADJV) >> 18) & 1;
        if (sw != 0) sy = (sy + ADJV) & 262143;
        return sx;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        scr_reset();
    endtask

    // Starts at a falling edge; returns sampled outputs after the second edge.
    task automatic do_step(input int w, input bit busy, input int busy_w,
                           output bit v, output int m);
        in_valid = 1'b1; in_word = 18'(w);
        @(negedge clk);
        if (busy) in_word = 18'(busy_w);
        else      in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        v = msg_valid;
        m = int'(msg_word);
    endtask

    task automatic step_expect(input int w, input int exp, input string req);
        bit v; int m;
        do_step(w, 1'b0, 0, v, m);
        chk(v == 1'b1, {req, " valid"}, int'(v), 1);
        chk(m == exp, req, m, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        summary();
        $finish;
    end

    initial begin
        bit v; int m, x, msg;

        // R1: reset state at the ports
        do_reset();
        chk(msg_valid == 1'b0, "R1 msg_valid", int'(msg_valid), 0);
        chk(err == 1'b0, "R1 err", int'(err), 0);
        chk(msg_word == 18'd0, "R1 msg_word", int'(msg_word), 0);

        // R4/R5: hand-computed sequence from reset values
        step_expect(0,      146133, "R4 negative first step");
        step_expect(200000, 31771,  "R4 borrow carried");
        step_expect(168229, 1,      "R5 tracker reduced");
        step_expect(110113, 258113, "R5 carry used, R8 top value");
        step_expect(20231,  0,      "R4 R5 both carries");

        // R2: single pulse, R9: hold while idle
        @(negedge clk);
        chk(msg_valid == 1'b0, "R2 single pulse", int'(msg_valid), 1'b0);
        repeat (3) @(negedge clk);
        chk(msg_word == 18'd0 && !msg_valid, "R9 idle hold", int'(msg_word), 0);

        // R7: out-of-range word discarded, err sticky
        do_reset();
        do_step(MODV, 1'b0, 0, v, m);
        chk(v == 1'b0, "R7 no valid on bad word", int'(v), 0);
        chk(err == 1'b1, "R7 err set", int'(err), 1);
        step_expect(0, 146133, "R7 state untouched");
        chk(err == 1'b1, "R7 err held", int'(err), 1);
        do_step(262143, 1'b0, 0, v, m);
        chk(v == 1'b0, "R7 max word dropped", int'(v), 0);

        // R6: input held during reduce phase is ignored
        do_reset();
        chk(err == 1'b0, "R1 err cleared", int'(err), 0);
        do_step(0, 1'b1, 5, v, m);
        chk(v == 1'b1 && m == 146133, "R6 step with busy input", m, 146133);
        @(negedge clk);
        chk(msg_valid == 1'b0, "R6 no extra step", int'(msg_valid), 0);
        step_expect(200000, 31771, "R6 busy word ignored");

        // R3: table of messages through the reference scrambler
        do_reset();
        for (int i = 0; i < N_VEC; i++) begin
            x = scr_step(VEC[i][0]);
            step_expect(x, VEC[i][0], "R3 table");
            repeat (VEC[i][1]) @(negedge clk);
        end

        // R3/R8: long random chain
        for (int i = 0; i < 3000; i++) begin
            msg = int'($urandom % MODV);
            x = scr_step(msg);
            do_step(x, 1'b0, 0, v, m);
            if (!v || m != msg) chk(1'b0, "R3 random chain", m, msg);
            else checks++;
            if (m >= MODV) chk(1'b0, "R8 range", m, MODV - 1);
        end

        summary();
        $finish;
    end
endmodule